// File: doc/BRIEF.md
# Windowed Register File with Drowsy Retention

This block is the integer register file of a small in-order core: 32 words of 32 bits, two combinational read ports and one synchronous write port. A command port, fed by the decoder when it sees a window-shrink or window-restore instruction at the start or end of a marked code section, picks how many registers stay live: all 32, the low 16, or the low 8. Registers outside the window go drowsy. They keep their contents, their write enable is gated off, and any access to them is refused and flagged.

Storage is split into groups of eight registers. A group leaves the drowsy state only after one wake cycle, and the `wake_busy` pin tells the pipeline to stall during that cycle. Groups that are dropped from the window go drowsy in the very next cycle. All pins are plain, level-style control and data. The ports carry no valid/ready handshake because every access completes in one cycle and nothing applies back-pressure. The only stall source is `wake_busy`, and the pipeline must honour it.

Top module: `rf_window_file`

## Requirements
- R1: After reset every group is awake (`drowsy_grp` = 0000), `wake_busy` and `access_viol` are low, and every register reads zero.
- R2: `cfg_mode` encoding: 2'b00 and 2'b11 keep registers 0..31 live, 2'b01 keeps 0..15, and 2'b10 keeps 0..7.
- R3: When `cfg_valid` is sampled high, the groups outside the new window show as drowsy from the next cycle on.
- R4: A group that re-enters the window stays drowsy for exactly one cycle after the command, with `wake_busy` high. In the cycle after that it is accessible and `wake_busy` is low. An access during the wake cycle is treated as an access to a drowsy register.
- R5: A write to a drowsy register is dropped. The register keeps its value while drowsy and reads it back after waking.
- R6: A read with its enable high that targets a drowsy register returns zero. A read with its enable low also returns zero.
- R7: `access_viol` is high for one cycle, in the cycle after any cycle that had an enabled read or a write aimed at a drowsy register. Otherwise it is low.
- R8: A read and a write to the same live register in the same cycle return the old value. The new value is visible from the next cycle.
- R9: `drowsy_grp[g]` reports group g (registers 8g..8g+7). Bit 0 is never set.
- R10: The two read ports are independent and may address any two registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | 5 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | 5 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| cfg_valid | input | 1 | Window command strobe |
| cfg_mode | input | 2 | Requested window size (see R2) |
| drowsy_grp | output | 4 | Per-group drowsy status |
| wake_busy | output | 1 | A group is in its wake cycle |
| access_viol | output | 1 | Previous cycle accessed a drowsy register |

## Verification
A drowsy flag stuck at the wrong value shows up in the same cycle: reads of that group return zero where data was expected, or return data where zero was expected. It also shows up one cycle later through `access_viol`. A write gate that leaks is silent until the group wakes, so the bench writes to every register of every drowsy group and then reads the whole file back after restoring the full window. A broken wake sequence shows up in the one cycle after the command, through `wake_busy`, `drowsy_grp` and a probe read of the waking group.

// File: rtl/rf_win_pkg.sv
package rf_win_pkg;

  typedef enum logic [1:0] {
    WIN_FULL    = 2'b00,
    WIN_HALF    = 2'b01,
    WIN_QUARTER = 2'b10,
    WIN_RSVD    = 2'b11
  } win_mode_e;

  // number of live groups for a mode, out of total_groups
  function automatic int live_groups(input win_mode_e m, input int total_groups);
    int n;
    case (m)
      WIN_HALF:    n = total_groups / 2;
      WIN_QUARTER: n = total_groups / 4;
      default:     n = total_groups;
    endcase
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/rf_win_ctrl.sv
module rf_win_ctrl
  import rf_win_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic [1:0]            cfg_mode,
  output logic [NUM_GROUPS-1:0] drowsy_o,
  output logic [NUM_GROUPS-1:0] waking_o
);

  logic [NUM_GROUPS-1:0] want;
  logic [NUM_GROUPS-1:0] drowsy_q;
  logic [NUM_GROUPS-1:0] wake_q;
  int                    live_cnt;

  always_comb begin
    live_cnt = live_groups(win_mode_e'(cfg_mode), NUM_GROUPS);
    for (int g = 0; g < NUM_GROUPS; g++) begin
      want[g] = (g < live_cnt);
    end
  end

  // per group: awake -> drowsy on shrink; drowsy -> waking -> awake on grow
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drowsy_q <= '0;
      wake_q   <= '0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (cfg_valid && !want[g]) begin
          drowsy_q[g] <= 1'b1;
          wake_q[g]   <= 1'b0;
        end else if (wake_q[g]) begin
          drowsy_q[g] <= 1'b0;
          wake_q[g]   <= 1'b0;
        end else if (cfg_valid && drowsy_q[g]) begin
          wake_q[g]   <= 1'b1;
        end
      end
    end
  end

  assign drowsy_o = drowsy_q;
  assign waking_o = wake_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_wake_chk
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q[g] |=> !wake_q[g]) else $error("wake lasted more than one cycle"); // R4
  end

  AST_SHRINK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_mode == WIN_QUARTER) |=> drowsy_o[NUM_GROUPS-1])
    else $error("top group not drowsy after shrink"); // R3

endmodule

// File: rtl/rf_win_bank.sv
module rf_win_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drowsy_i,
  input  logic              wr_en_i,
  input  logic [LOC_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LOC_W-1:0]  rd_idx0_i,
  input  logic [LOC_W-1:0]  rd_idx1_i,
  output logic [DATA_W-1:0] rd_data0_o,
  output logic [DATA_W-1:0] rd_data1_o
);

  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic                         wr_gate;

  // retention: the write enable of a drowsy group is forced off
  assign wr_gate = wr_en_i & ~drowsy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_gate) begin
      mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data0_o = mem[rd_idx0_i];
  assign rd_data1_o = mem[rd_idx1_i];

  AST_RETAIN_DROWSY: assert property (@(posedge clk) disable iff (!rst_n)
    drowsy_i |=> $stable(mem)) else $error("drowsy bank changed"); // R5

endmodule

// File: rtl/rf_win_rdport.sv
module rf_win_rdport #(
  parameter int NUM_GROUPS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int LOC_W      = 3
) (
  input  logic                              en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_GROUPS-1:0][DATA_W-1:0] grp_word_i,
  input  logic [NUM_GROUPS-1:0]             drowsy_i,
  output logic [DATA_W-1:0]                 data_o,
  output logic                              bad_o
);

  localparam int GRP_W = ADDR_W - LOC_W;

  logic [GRP_W-1:0] grp;
  logic             asleep;

  assign grp    = addr_i[ADDR_W-1:LOC_W];
  assign asleep = drowsy_i[grp];
  assign bad_o  = en_i & asleep;
  assign data_o = (en_i && !asleep) ? grp_word_i[grp] : '0;

endmodule

// File: rtl/rf_window_file.sv
module rf_window_file
  import rf_win_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int GROUP_SZ = 8,
  localparam int NUM_GROUPS = NUM_REGS / GROUP_SZ,
  localparam int ADDR_W     = $clog2(NUM_REGS),
  localparam int LOC_W      = $clog2(GROUP_SZ),
  localparam int GRP_W      = ADDR_W - LOC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd0_en,
  input  logic [ADDR_W-1:0]     rd0_addr,
  output logic [DATA_W-1:0]     rd0_data,
  input  logic                  rd1_en,
  input  logic [ADDR_W-1:0]     rd1_addr,
  output logic [DATA_W-1:0]     rd1_data,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  cfg_valid,
  input  logic [1:0]            cfg_mode,
  output logic [NUM_GROUPS-1:0] drowsy_grp,
  output logic                  wake_busy,
  output logic                  access_viol
);

  logic [NUM_GROUPS-1:0]             drowsy_q;
  logic [NUM_GROUPS-1:0]             waking_q;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] bank_rd0;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] bank_rd1;
  logic [1:0]                        rd_en_v;
  logic [1:0][ADDR_W-1:0]            rd_addr_v;
  logic [1:0][DATA_W-1:0]            rd_data_v;
  logic [1:0]                        rd_bad_v;
  logic                              wr_bad;
  logic                              viol_q;

  rf_win_ctrl #(.NUM_GROUPS(NUM_GROUPS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_mode  (cfg_mode),
    .drowsy_o  (drowsy_q),
    .waking_o  (waking_q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_addr[ADDR_W-1:LOC_W] == GRP_W'(g));

    rf_win_bank #(.DATA_W(DATA_W), .DEPTH(GROUP_SZ)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .drowsy_i   (drowsy_q[g]),
      .wr_en_i    (bank_we),
      .wr_idx_i   (wr_addr[LOC_W-1:0]),
      .wr_data_i  (wr_data),
      .rd_idx0_i  (rd0_addr[LOC_W-1:0]),
      .rd_idx1_i  (rd1_addr[LOC_W-1:0]),
      .rd_data0_o (bank_rd0[g]),
      .rd_data1_o (bank_rd1[g])
    );
  end

  assign rd_en_v   = {rd1_en, rd0_en};
  assign rd_addr_v = {rd1_addr, rd0_addr};

  for (genvar p = 0; p < 2; p++) begin : g_rport
    rf_win_rdport #(
      .NUM_GROUPS (NUM_GROUPS),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .LOC_W      (LOC_W)
    ) port_i (
      .en_i       (rd_en_v[p]),
      .addr_i     (rd_addr_v[p]),
      .grp_word_i ((p == 0) ? bank_rd0 : bank_rd1),
      .drowsy_i   (drowsy_q),
      .data_o     (rd_data_v[p]),
      .bad_o      (rd_bad_v[p])
    );
  end

  assign rd0_data = rd_data_v[0];
  assign rd1_data = rd_data_v[1];
  assign wr_bad   = wr_en && drowsy_q[wr_addr[ADDR_W-1:LOC_W]];

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= wr_bad | (|rd_bad_v);
  end

  assign access_viol = viol_q;
  assign drowsy_grp  = drowsy_q;
  assign wake_busy   = |waking_q;

  AST_GRP0_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !drowsy_grp[0]) else $error("group 0 went drowsy"); // R9

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && drowsy_grp[rd0_addr[ADDR_W-1:LOC_W]]) |-> (rd0_data == '0))
    else $error("drowsy read leaked data"); // R6

  AST_VIOL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && drowsy_grp[wr_addr[ADDR_W-1:LOC_W]]) |=> access_viol)
    else $error("drowsy write not flagged"); // R7

  AST_BUSY_MEANS_DROWSY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_busy |-> (drowsy_grp != '0)) else $error("busy with no drowsy group"); // R4

endmodule

// File: tb/rf_window_file_tb.sv
`timescale 1ns/1ps
module rf_window_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd0_en = 1'b0, rd1_en = 1'b0, wr_en = 1'b0, cfg_valid = 1'b0;
  logic [4:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cfg_mode = '0;
  logic [31:0] rd0_data, rd1_data;
  logic [3:0]  drowsy_grp;
  logic        wake_busy, access_viol;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] model [32];
  logic [3:0]  cur_drowsy = 4'b0000;

  always #10 clk = ~clk;

  rf_window_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
    .drowsy_grp(drowsy_grp), .wake_busy(wake_busy), .access_viol(access_viol)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_drowsy(input logic [1:0] m);
    int act;
    logic [3:0] r;
    act = (m == 2'b01) ? 2 : ((m == 2'b10) ? 1 : 4);
    for (int g = 0; g < 4; g++) r[g] = (g >= act);
    return r;
  endfunction

  function automatic logic [31:0] pat(input int i, input int k);
    return 32'((i + 1) * 32'h0101_0101 + k * 32'h0010_0007);
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    return cur_drowsy[a / 8] ? 32'h0 : model[a];
  endfunction

  // R2 R3 R4: window command plus wake-cycle probe
  task automatic do_cfg(input logic [1:0] m);
    logic [3:0] nw, grow;
    int top;
    nw   = exp_drowsy(m);
    grow = cur_drowsy & ~nw;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_mode = m;
    @(negedge clk);
    cfg_valid = 1'b0;
    check(wake_busy == (|grow), "R4 busy in wake cycle", 32'(wake_busy), 32'(|grow));
    check(drowsy_grp == (cur_drowsy | nw), "R3 drowsy after command", 32'(drowsy_grp), 32'(cur_drowsy | nw));
    check(access_viol == 1'b0, "R7 no viol after idle", 32'(access_viol), 32'h0);
    if (|grow) begin
      top = 0;
      for (int g = 0; g < 4; g++) if (grow[g]) top = g;
      rd0_en = 1'b1; rd0_addr = 5'(top * 8);
      #1 check(rd0_data == 32'h0, "R4 read during wake is zero", rd0_data, 32'h0);
      @(negedge clk);
      rd0_en = 1'b0;
      check(access_viol == 1'b1, "R7 viol for wake-cycle read", 32'(access_viol), 32'h1);
    end else begin
      @(negedge clk);
    end
    cur_drowsy = nw;
    check(drowsy_grp == nw, "R2 window settled", 32'(drowsy_grp), 32'(nw));
    check(drowsy_grp[0] == 1'b0, "R9 group 0 live", 32'(drowsy_grp[0]), 32'h0);
    check(wake_busy == 1'b0, "R4 busy cleared", 32'(wake_busy), 32'h0);
    @(negedge clk);
    check(access_viol == 1'b0, "R7 viol lasts one cycle", 32'(access_viol), 32'h0);
  endtask

  // R5 R7 R8: write with same-address read probe
  task automatic do_write(input int a, input logic [31:0] d);
    bit sleepy;
    sleepy = cur_drowsy[a / 8];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    rd0_en = 1'b1; rd0_addr = 5'(a);
    #1 check(rd0_data == exp_rd(a), "R8 old value on same-cycle read", rd0_data, exp_rd(a));
    @(negedge clk);
    wr_en = 1'b0; rd0_en = 1'b0;
    check(access_viol == sleepy, "R7 viol on drowsy write", 32'(access_viol), 32'(sleepy));
    if (!sleepy) model[a] = d;
  endtask

  // R5 R6 R10: both ports sweep the whole file
  task automatic read_sweep();
    bit prev_bad;
    int b;
    prev_bad = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      check(access_viol == prev_bad, "R7 viol after read", 32'(access_viol), 32'(prev_bad));
      b = (i * 7 + 3) % 32;
      rd0_en = 1'b1; rd0_addr = 5'(i);
      rd1_en = 1'b1; rd1_addr = 5'(b);
      #1;
      check(rd0_data == exp_rd(i), "R6 R5 port0 data", rd0_data, exp_rd(i));
      check(rd1_data == exp_rd(b), "R10 port1 data", rd1_data, exp_rd(b));
      prev_bad = cur_drowsy[i / 8] | cur_drowsy[b / 8];
    end
    @(negedge clk);
    rd0_en = 1'b0; rd1_en = 1'b0;
    check(access_viol == prev_bad, "R7 viol after last read", 32'(access_viol), 32'(prev_bad));
    #1 check(rd0_data == 32'h0, "R6 disabled read is zero", rd0_data, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(drowsy_grp == 4'b0000, "R1 reset drowsy", 32'(drowsy_grp), 32'h0);
    check(wake_busy == 1'b0, "R1 reset busy", 32'(wake_busy), 32'h0);
    check(access_viol == 1'b0, "R1 reset viol", 32'(access_viol), 32'h0);
    read_sweep();  // R1 all zero
    for (int i = 0; i < 32; i++) do_write(i, pat(i, 0));
    read_sweep();
    begin
      logic [1:0] seq [6] = '{2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b00};
      for (int s = 0; s < 6; s++) begin
        do_cfg(seq[s]);
        for (int i = 0; i < 32; i++) do_write(i, pat(i, s + 1));
        read_sweep();
      end
    end
    // R3: shrink and grow back-to-back, retention checked by readback
    do_cfg(2'b10);
    for (int i = 0; i < 32; i++) do_write(i, pat(i, 9));
    do_cfg(2'b00);
    read_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule